// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block serves a configuration controller that keeps a device's 4 KB configuration space in a dword-wide memory. Extended capabilities in that space form a singly linked chain. The chain always begins at byte offset 256, and each entry opens with a header dword that names the capability and points to the next entry.

The block has two operations. A lookup follows the chain to the first entry whose capability ID equals the requested one. It returns that entry's offset and the offset of the entry visited just before it. A lookup for ID zero never hits a real entry, so it returns the chain tail as the previous offset. An append uses the same tail search to link a new capability. It rewrites the tail's next field in place and then writes the new header. An append at offset 256 instead replaces the head header but keeps the head's existing next pointer.

Requests enter through a valid/ready handshake. Results come back with a one-cycle done strobe. The memory side is a single port with one cycle of read latency.

Top module: `ecap_list_walker`

## Requirements
- R1: A header dword holds the capability ID in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. The memory word address is the byte offset shifted right by two.
- R2: `reqReady` is high only while the block is idle, and a request is taken on a cycle with `reqValid` and `reqReady` both high. `rspDone` is high for exactly one cycle per request, and the response fields stay stable until the next response.
- R3: A lookup (`reqAppend`=0) first reads offset 256. If that header is all zeros, the response is found=0, offset=0, prev=0, err=0.
- R4: When the lookup reaches an entry whose ID equals `reqCapId`, it responds found=1, offset=that entry and prev=the entry visited before it. Prev is 0 when the match is the first entry.
- R5: When the lookup reaches an entry with next=0 and no match, it responds found=0, offset=0 and prev=that last entry. A lookup for ID 0 therefore returns the tail as prev.
- R6: A next pointer that is below 256, above 4088 or not dword aligned stops the walk with err=1, found=0, offset=0 and prev=0.
- R7: If the walk would follow a 1025th next pointer, it stops with err=1, so a circular chain always gets a response.
- R8: An append (`reqAppend`=1) at offset 256 writes {next kept from the old head header, version, ID} at 256. The response is found=1, offset=256, prev=0.
- R9: An append at any other offset first rewrites the tail header's next field to the new offset, keeping the tail's ID and version. It then writes {0, version, ID} at the new offset. The response is found=1, offset=new, prev=tail. An append to an empty chain at an offset other than 256 returns err=1 and writes nothing.
- R10: An append whose offset is unaligned or below 256, whose size is below 8 bytes, or whose end (offset+size) lies beyond 4096 returns err=1 with no memory write. An end of exactly 4096 is accepted.
- R11: Read data is taken one cycle after `memRdEn`, and a read and a write never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block idle, request accepted |
| reqAppend | input | 1 | 1 = append, 0 = lookup |
| reqCapId | input | 16 | Capability ID to look up or to append |
| reqCapVer | input | 4 | Version of the appended capability |
| reqOffset | input | 12 | Byte offset of the appended capability |
| reqSize | input | 13 | Byte size of the appended capability |
| rspDone | output | 1 | One-cycle response strobe |
| rspFound | output | 1 | Match found, or append performed |
| rspErr | output | 1 | Malformed chain, loop guard or bad append |
| rspOffset | output | 12 | Matching or appended entry offset, else 0 |
| rspPrev | output | 12 | Previous or tail entry offset |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 10 | Memory dword address |
| memWrData | output | 32 | Memory write data |
| memRdData | input | 32 | Memory read data, one cycle after the read |

## Verification
The bench goes after the corners a walker most often gets wrong:
- A match on the very first entry must report prev 0. A design that loads prev from a stale register would report garbage there.
- A lookup for ID zero must return the tail. A design with an off-by-one advance would return the entry before the tail.
- A self-pointing chain must end in an error and not a hang.
- A head append must keep the old next pointer. A design that cleared it would detach the whole chain.
- An append ending exactly at 4096 must pass. A design with a strict bound would reject it.
- Bad appends must leave memory untouched. The bench counts every memory write to confirm this.
- A tail rewrite must keep the tail's ID and version. A design that rebuilt the header would corrupt them.

// File: rtl/ecap_walk_pkg.sv
package ecap_walk_pkg;

  typedef enum logic [2:0] {
    RES_FOUND,
    RES_END,
    RES_EMPTY,
    RES_ERR,
    RES_APPEND
  } res_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_WR_TAIL,
    ST_WR_NEW,
    ST_DONE
  } walk_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic     ldReq;
    logic     ldStart;
    logic     rdIssue;
    logic     capHdr;
    logic     advance;
    logic     wrTail;
    logic     wrNew;
    logic     ldRes;
    res_sel_e resSel;
  } walk_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic opAppend;
    logic argsBad;
    logic atStart;
    logic hdrZero;
    logic idMatch;
    logic nextZero;
    logic nextBad;
    logic hopLimit;
    logic appendAtStart;
  } walk_stat_t;

endpackage

// File: rtl/ecap_walk_dp.sv
module ecap_walk_dp
  import ecap_walk_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int ID_W      = 16,
  parameter int VER_W     = 4,
  parameter int START_OFF = 256,
  parameter int MIN_BYTES = 8,
  parameter int MAX_HOPS  = 1024
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  walk_strobe_t                   strobe,
  output walk_stat_t                     stat,
  input  logic                           reqAppend,
  input  logic [ID_W-1:0]                reqCapId,
  input  logic [VER_W-1:0]               reqCapVer,
  input  logic [OFF_W-1:0]               reqOffset,
  input  logic [OFF_W:0]                 reqSize,
  output logic                           rspFound,
  output logic                           rspErr,
  output logic [OFF_W-1:0]               rspOffset,
  output logic [OFF_W-1:0]               rspPrev,
  output logic                           memRdEn,
  output logic                           memWrEn,
  output logic [OFF_W-3:0]               memAddr,
  output logic [ID_W+VER_W+OFF_W-1:0]    memWrData,
  input  logic [ID_W+VER_W+OFF_W-1:0]    memRdData
);

  localparam int HDR_W     = ID_W + VER_W + OFF_W;
  localparam int LOW_W     = ID_W + VER_W;
  localparam int CFG_BYTES = 1 << OFF_W;
  localparam int SIZE_W    = OFF_W + 1;
  localparam int SUM_W     = SIZE_W + 1;
  localparam int HOP_W     = $clog2(MAX_HOPS + 1);
  localparam logic [OFF_W-1:0] START    = OFF_W'(START_OFF);
  localparam logic [OFF_W-1:0] LAST_HDR = OFF_W'(CFG_BYTES - 8);

  logic              opAppendQ;
  logic [ID_W-1:0]   idQ;
  logic [VER_W-1:0]  verQ;
  logic [OFF_W-1:0]  newOff;
  logic [OFF_W-1:0]  curOff;
  logic [OFF_W-1:0]  prevOff;
  logic [HDR_W-1:0]  lastHdr;
  logic [HOP_W-1:0]  hopCnt;

  logic [ID_W-1:0]   hdrId;
  logic [OFF_W-1:0]  hdrNext;
  logic [SUM_W-1:0]  endOff;
  logic [OFF_W-1:0]  newNext;

  assign hdrId   = memRdData[ID_W-1:0];
  assign hdrNext = memRdData[HDR_W-1 -: OFF_W];
  assign endOff  = SUM_W'(reqOffset) + SUM_W'(reqSize);

  // status towards the control
  always_comb begin
    stat.opAppend      = opAppendQ;
    stat.argsBad       = (reqOffset[1:0] != 2'b00) || (reqOffset < START) ||
                         (reqSize < SIZE_W'(MIN_BYTES)) ||
                         (endOff > SUM_W'(CFG_BYTES));
    stat.atStart       = (curOff == START);
    stat.hdrZero       = (memRdData == '0);
    stat.idMatch       = !opAppendQ && (hdrId == idQ);
    stat.nextZero      = (hdrNext == '0);
    stat.nextBad       = (hdrNext < START) || (hdrNext > LAST_HDR) ||
                         (hdrNext[1:0] != 2'b00);
    stat.hopLimit      = (hopCnt == HOP_W'(MAX_HOPS));
    stat.appendAtStart = (newOff == START);
  end

  // request capture and walk registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAppendQ <= 1'b0;
      idQ       <= '0;
      verQ      <= '0;
      newOff    <= '0;
      curOff    <= START;
      prevOff   <= '0;
      lastHdr   <= '0;
      hopCnt    <= '0;
    end else begin
      if (strobe.ldReq) begin
        opAppendQ <= reqAppend;
        idQ       <= reqCapId;
        verQ      <= reqCapVer;
        newOff    <= reqOffset;
      end
      if (strobe.ldStart) begin
        curOff  <= START;
        prevOff <= '0;
        hopCnt  <= '0;
      end else if (strobe.advance) begin
        prevOff <= curOff;
        curOff  <= hdrNext;
        hopCnt  <= hopCnt + 1'b1;
      end
      if (strobe.capHdr) lastHdr <= memRdData;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspFound  <= 1'b0;
      rspErr    <= 1'b0;
      rspOffset <= '0;
      rspPrev   <= '0;
    end else if (strobe.ldRes) begin
      unique case (strobe.resSel)
        RES_FOUND: begin
          rspFound <= 1'b1; rspErr <= 1'b0; rspOffset <= curOff; rspPrev <= prevOff;
        end
        RES_END: begin
          rspFound <= 1'b0; rspErr <= 1'b0; rspOffset <= '0; rspPrev <= curOff;
        end
        RES_APPEND: begin
          rspFound  <= 1'b1; rspErr <= 1'b0; rspOffset <= newOff;
          rspPrev   <= (newOff == START) ? '0 : curOff;
        end
        RES_ERR: begin
          rspFound <= 1'b0; rspErr <= 1'b1; rspOffset <= '0; rspPrev <= '0;
        end
        default: begin
          rspFound <= 1'b0; rspErr <= 1'b0; rspOffset <= '0; rspPrev <= '0;
        end
      endcase
    end
  end

  // memory port
  assign newNext   = (newOff == START) ? lastHdr[HDR_W-1 -: OFF_W] : '0;
  assign memRdEn   = strobe.rdIssue;
  assign memWrEn   = strobe.wrTail | strobe.wrNew;
  assign memAddr   = strobe.wrNew ? newOff[OFF_W-1:2] : curOff[OFF_W-1:2];
  assign memWrData = strobe.wrNew ? {newNext, verQ, idQ}
                                  : {newOff, lastHdr[LOW_W-1:0]};

  p_rd_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (curOff >= START && curOff <= LAST_HDR && curOff[1:0] == 2'b00));

  p_new_hdr_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrNew |-> (newOff >= START && newOff[1:0] == 2'b00));

  p_hops_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
    hopCnt <= HOP_W'(MAX_HOPS));

endmodule

// File: rtl/ecap_walk_ctrl.sv
module ecap_walk_ctrl
  import ecap_walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqAppend,
  input  walk_stat_t   stat,
  output logic         reqReady,
  output logic         rspDone,
  output walk_strobe_t strobe
);

  walk_state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    strobe   = '0;
    reqReady = 1'b0;
    rspDone  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.ldReq = 1'b1;
          if (reqAppend && stat.argsBad) begin
            strobe.ldRes  = 1'b1;
            strobe.resSel = RES_ERR;
            nxt = ST_DONE;
          end else begin
            strobe.ldStart = 1'b1;
            nxt = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        strobe.rdIssue = 1'b1;
        nxt = ST_WAIT;
      end
      ST_WAIT: begin
        strobe.capHdr = 1'b1;
        if (stat.opAppend && stat.appendAtStart) begin
          nxt = ST_WR_NEW;
        end else if (stat.atStart && stat.hdrZero) begin
          strobe.ldRes  = 1'b1;
          strobe.resSel = stat.opAppend ? RES_ERR : RES_EMPTY;
          nxt = ST_DONE;
        end else if (stat.idMatch) begin
          strobe.ldRes  = 1'b1;
          strobe.resSel = RES_FOUND;
          nxt = ST_DONE;
        end else if (stat.nextZero) begin
          if (stat.opAppend) begin
            nxt = ST_WR_TAIL;
          end else begin
            strobe.ldRes  = 1'b1;
            strobe.resSel = RES_END;
            nxt = ST_DONE;
          end
        end else if (stat.nextBad || stat.hopLimit) begin
          strobe.ldRes  = 1'b1;
          strobe.resSel = RES_ERR;
          nxt = ST_DONE;
        end else begin
          strobe.advance = 1'b1;
          nxt = ST_ISSUE;
        end
      end
      ST_WR_TAIL: begin
        strobe.wrTail = 1'b1;
        nxt = ST_WR_NEW;
      end
      ST_WR_NEW: begin
        strobe.wrNew  = 1'b1;
        strobe.ldRes  = 1'b1;
        strobe.resSel = RES_APPEND;
        nxt = ST_DONE;
      end
      ST_DONE: begin
        rspDone = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_read_then_decode_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdIssue |=> (strobe.capHdr && !strobe.wrTail && !strobe.wrNew));

endmodule

// File: rtl/ecap_list_walker.sv
module ecap_list_walker
  import ecap_walk_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int ID_W      = 16,
  parameter int VER_W     = 4,
  parameter int START_OFF = 256,
  parameter int MIN_BYTES = 8,
  parameter int MAX_HOPS  = 1024
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic                        reqAppend,
  input  logic [ID_W-1:0]             reqCapId,
  input  logic [VER_W-1:0]            reqCapVer,
  input  logic [OFF_W-1:0]            reqOffset,
  input  logic [OFF_W:0]              reqSize,
  output logic                        rspDone,
  output logic                        rspFound,
  output logic                        rspErr,
  output logic [OFF_W-1:0]            rspOffset,
  output logic [OFF_W-1:0]            rspPrev,
  output logic                        memRdEn,
  output logic                        memWrEn,
  output logic [OFF_W-3:0]            memAddr,
  output logic [ID_W+VER_W+OFF_W-1:0] memWrData,
  input  logic [ID_W+VER_W+OFF_W-1:0] memRdData
);

  walk_strobe_t strobe;
  walk_stat_t   stat;

  ecap_walk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqAppend(reqAppend),
    .stat     (stat),
    .reqReady (reqReady),
    .rspDone  (rspDone),
    .strobe   (strobe)
  );

  ecap_walk_dp #(
    .OFF_W    (OFF_W),
    .ID_W     (ID_W),
    .VER_W    (VER_W),
    .START_OFF(START_OFF),
    .MIN_BYTES(MIN_BYTES),
    .MAX_HOPS (MAX_HOPS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .stat     (stat),
    .reqAppend(reqAppend),
    .reqCapId (reqCapId),
    .reqCapVer(reqCapVer),
    .reqOffset(reqOffset),
    .reqSize  (reqSize),
    .rspFound (rspFound),
    .rspErr   (rspErr),
    .rspOffset(rspOffset),
    .rspPrev  (rspPrev),
    .memRdEn  (memRdEn),
    .memWrEn  (memWrEn),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .memRdData(memRdData)
  );

  p_found_offset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && rspFound) |-> (rspOffset >= OFF_W'(START_OFF)));

  p_err_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && rspErr) |-> (!rspFound && rspOffset == '0 && rspPrev == '0));

  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

endmodule

// File: tb/ecap_list_walker_tb.sv
module ecap_list_walker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqAppend = 1'b0;
  logic [15:0] reqCapId = '0;
  logic [3:0]  reqCapVer = '0;
  logic [11:0] reqOffset = '0;
  logic [12:0] reqSize = '0;
  logic        rspDone, rspFound, rspErr;
  logic [11:0] rspOffset, rspPrev;
  logic        memRdEn, memWrEn;
  logic [9:0]  memAddr;
  logic [31:0] memWrData;
  logic [31:0] memRdData = '0;

  logic [31:0] mem [0:1023];
  logic        pokeEn = 1'b0;
  logic [9:0]  pokeAddr = '0;
  logic [31:0] pokeData = '0;
  int          wrCount = 0;
  int          vectors = 0;
  int          miscompares = 0;

  // captured response
  logic        gFound, gErr;
  logic [11:0] gOff, gPrev;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecap_list_walker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAppend(reqAppend), .reqCapId(reqCapId), .reqCapVer(reqCapVer),
    .reqOffset(reqOffset), .reqSize(reqSize), .rspDone(rspDone),
    .rspFound(rspFound), .rspErr(rspErr), .rspOffset(rspOffset),
    .rspPrev(rspPrev), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData)
  );

  // config memory model: one cycle read latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr];
    if (memWrEn) begin
      mem[memAddr] <= memWrData;
      wrCount <= wrCount + 1;
    end
    if (pokeEn) mem[pokeAddr] <= pokeData;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int byteOff, input logic [31:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = 10'(byteOff >> 2); pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic runReq(input bit app, input logic [15:0] id, input logic [3:0] ver,
                        input logic [11:0] off, input logic [12:0] sz);
    @(negedge clk);
    reqValid = 1'b1; reqAppend = app; reqCapId = id; reqCapVer = ver;
    reqOffset = off; reqSize = sz;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspDone) @(negedge clk);
    gFound = rspFound; gErr = rspErr; gOff = rspOffset; gPrev = rspPrev;
    @(negedge clk);
    if (rspDone !== 1'b0) begin
      miscompares++;
      $display("FAIL R2 done held act=%b exp=0", rspDone);
    end
  endtask

  // reference lookup derived from the requirements
  function automatic void refFind(input logic [15:0] id, output bit f, output bit e,
                                  output logic [11:0] o, output logic [11:0] p);
    logic [11:0] cur, prv, nx;
    logic [31:0] h;
    int hops;
    cur = 12'd256; prv = '0; hops = 0;
    f = 0; e = 0; o = '0; p = '0;
    if (mem[64] == 32'h0) return;
    for (int i = 0; i < 1100; i++) begin
      h = mem[cur >> 2];
      if (h[15:0] == id) begin f = 1; o = cur; p = prv; return; end
      nx = h[31:20];
      if (nx == 0) begin o = '0; p = cur; return; end
      if (nx < 256 || nx > 4088 || nx[1:0] != 0 || hops == 1024) begin
        e = 1; o = '0; p = '0; return;
      end
      prv = cur; cur = nx; hops++;
    end
    e = 1;
  endfunction

  task automatic checkFind(input string tag, input logic [15:0] id);
    bit f, e; logic [11:0] o, p;
    refFind(id, f, e, o, p);
    runReq(1'b0, id, 4'h0, 12'h0, 13'h0);
    chk({tag, " found"}, 32'(gFound), 32'(f));
    chk({tag, " err"},   32'(gErr),   32'(e));
    chk({tag, " off"},   32'(gOff),   32'(o));
    chk({tag, " prev"},  32'(gPrev),  32'(p));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    int w0;
    int offs [0:15];
    int nOff;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R2 reset ready", 32'(reqReady), 32'd1);
    chk("R2 reset done",  32'(rspDone),  32'd0);
    chk("R11 reset rd",   32'(memRdEn),  32'd0);
    chk("R11 reset wr",   32'(memWrEn),  32'd0);

    // R3: empty chain
    poke(256, 32'h0);
    runReq(1'b0, 16'h0005, 4'h0, 12'h0, 13'h0);
    chk("R3 empty found", 32'(gFound), 32'd0);
    chk("R3 empty off",   32'(gOff),   32'd0);
    chk("R3 empty prev",  32'(gPrev),  32'd0);
    chk("R3 empty err",   32'(gErr),   32'd0);

    // R9: append to empty chain off the head is an error without writes
    w0 = wrCount;
    runReq(1'b1, 16'h0009, 4'h1, 12'h200, 13'd16);
    chk("R9 empty append err", 32'(gErr), 32'd1);
    chk("R9 empty append no write", 32'(wrCount - w0), 32'd0);

    // R8: head append into empty chain
    runReq(1'b1, 16'h0001, 4'h1, 12'h100, 13'd16);
    chk("R8 head hdr R1",  mem[64], 32'h0001_0001);
    chk("R8 head found",   32'(gFound), 32'd1);
    chk("R8 head off",     32'(gOff),   32'h100);
    chk("R8 head prev",    32'(gPrev),  32'h0);

    // R9: tail appends
    runReq(1'b1, 16'h000B, 4'h2, 12'h200, 13'h40);
    chk("R9 tail patched R1", mem[64],   32'h2001_0001);
    chk("R9 new hdr",         mem[128],  32'h0002_000B);
    chk("R9 off",             32'(gOff), 32'h200);
    chk("R9 prev",            32'(gPrev),32'h100);
    runReq(1'b1, 16'h000C, 4'h3, 12'h180, 13'd8);
    chk("R9 tail2 patched", mem[128], 32'h1802_000B);
    chk("R9 new hdr2",      mem[96],  32'h0003_000C);
    chk("R9 prev2",         32'(gPrev), 32'h200);

    // R4 / R5 lookups on the directed chain 0x100 -> 0x200 -> 0x180
    runReq(1'b0, 16'h0001, 4'h0, 12'h0, 13'h0);
    chk("R4 first match off",  32'(gOff),  32'h100);
    chk("R4 first match prev", 32'(gPrev), 32'h0);
    runReq(1'b0, 16'h000B, 4'h0, 12'h0, 13'h0);
    chk("R4 mid match off",  32'(gOff),  32'h200);
    chk("R4 mid match prev", 32'(gPrev), 32'h100);
    runReq(1'b0, 16'h000C, 4'h0, 12'h0, 13'h0);
    chk("R4 last match prev", 32'(gPrev), 32'h200);
    runReq(1'b0, 16'h0077, 4'h0, 12'h0, 13'h0);
    chk("R5 miss found", 32'(gFound), 32'd0);
    chk("R5 miss prev",  32'(gPrev),  32'h180);
    runReq(1'b0, 16'h0000, 4'h0, 12'h0, 13'h0);
    chk("R5 id0 off",  32'(gOff),  32'h0);
    chk("R5 id0 prev", 32'(gPrev), 32'h180);

    // R10: bad append arguments, no writes
    w0 = wrCount;
    runReq(1'b1, 16'h0044, 4'h1, 12'h202, 13'd16);
    chk("R10 unaligned err", 32'(gErr), 32'd1);
    runReq(1'b1, 16'h0044, 4'h1, 12'h080, 13'd16);
    chk("R10 low offset err", 32'(gErr), 32'd1);
    runReq(1'b1, 16'h0044, 4'h1, 12'h300, 13'd4);
    chk("R10 short size err", 32'(gErr), 32'd1);
    runReq(1'b1, 16'h0044, 4'h1, 12'hFF0, 13'h20);
    chk("R10 overrun err", 32'(gErr), 32'd1);
    chk("R10 no writes", 32'(wrCount - w0), 32'd0);
    chk("R10 tail untouched", mem[96], 32'h0003_000C);
    // end exactly at 4096 is legal
    runReq(1'b1, 16'h0045, 4'h5, 12'hFF8, 13'd8);
    chk("R10 edge ok err", 32'(gErr), 32'd0);
    chk("R10 edge hdr",    mem[1022], 32'h0005_0045);
    chk("R10 edge tail",   mem[96],   32'hFF83_000C);

    // R8: head append on populated chain keeps next
    runReq(1'b1, 16'h0005, 4'h4, 12'h100, 13'd16);
    chk("R8 keep next", mem[64], 32'h2004_0005);

    // R6: malformed next pointers
    poke(256, 32'h0FC0_0001);
    runReq(1'b0, 16'h0009, 4'h0, 12'h0, 13'h0);
    chk("R6 low next err", 32'(gErr), 32'd1);
    chk("R6 low next prev", 32'(gPrev), 32'd0);
    poke(256, 32'h1020_0001);
    runReq(1'b0, 16'h0009, 4'h0, 12'h0, 13'h0);
    chk("R6 unaligned next err", 32'(gErr), 32'd1);
    poke(256, 32'hFFC0_0001);
    runReq(1'b0, 16'h0009, 4'h0, 12'h0, 13'h0);
    chk("R6 high next err", 32'(gErr), 32'd1);

    // R7: circular chain
    poke(256, 32'h1000_0001);
    runReq(1'b0, 16'h0002, 4'h0, 12'h0, 13'h0);
    chk("R7 loop err",   32'(gErr),   32'd1);
    chk("R7 loop found", 32'(gFound), 32'd0);
    runReq(1'b0, 16'h0001, 4'h0, 12'h0, 13'h0);
    chk("R7 loop early match", 32'(gFound), 32'd1);

    // random chains with lookups and appends
    for (int l = 0; l < 10; l++) begin
      int n;
      n = $urandom_range(1, 6);
      offs[0] = 256;
      nOff = 1;
      while (nOff < n) begin
        int cand; bit dup;
        cand = 256 + 4 * $urandom_range(1, 958);
        dup = 0;
        for (int k = 0; k < nOff; k++) if (offs[k] == cand) dup = 1;
        if (!dup) begin offs[nOff] = cand; nOff++; end
      end
      for (int k = 0; k < n; k++) begin
        logic [11:0] nx;
        nx = (k < n - 1) ? 12'(offs[k+1]) : 12'h0;
        poke(offs[k], {nx, 4'($urandom_range(0, 15)), 16'($urandom_range(1, 8))});
      end
      for (int q = 0; q < 12; q++) checkFind("R4 R5 random find", 16'($urandom_range(0, 9)));
      for (int a = 0; a < 2; a++) begin
        int cand; bit dup; bit f, e; logic [11:0] o, p;
        logic [31:0] tailHdr; logic [15:0] id; logic [3:0] ver; int sz;
        dup = 1;
        while (dup) begin
          cand = 256 + 4 * $urandom_range(1, 958);
          dup = 0;
          for (int k = 0; k < nOff; k++) if (offs[k] == cand) dup = 1;
        end
        offs[nOff] = cand; nOff++;
        refFind(16'h0, f, e, o, p);
        tailHdr = mem[p >> 2];
        id  = 16'($urandom_range(1, 65535));
        ver = 4'($urandom_range(0, 15));
        sz  = $urandom_range(8, 4096 - cand);
        runReq(1'b1, id, ver, 12'(cand), 13'(sz));
        chk("R9 random append found", 32'(gFound), 32'd1);
        chk("R9 random append prev",  32'(gPrev),  32'(p));
        chk("R9 random tail patch",   mem[p >> 2], {12'(cand), tailHdr[19:0]});
        chk("R9 random new hdr",      mem[cand >> 2], {12'h0, ver, id});
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule